// File: doc/BRIEF.md
# Fault Grouping Redundancy Pre-Analyzer

This block sits beside a memory test engine and takes in the addresses of failing cells, one row and column pair per handshake, while the test runs. It sorts the failures into connected groups as they arrive. Two failures are in the same group when they lie on a common row or a common column, and the relation is transitive. A failure that shares no line with any other stays a group of one. When a new failure joins two groups that were separate until then, the block relabels one group's members one entry per clock cycle. Fault entry stalls until the relabel is done.

When the test signals its end, the block runs a single-cycle analysis against the spare rows and spare columns set by parameters. A line counts as a forced repair when it holds more failures than the spares of the other kind can cover. The memory is rejected at once if the stored failures overflowed the fault store, if there are more groups than spares in total, or if more lines are forced than spares of that kind exist. Otherwise the block reports that a further search is needed. A readout port shows, for any storage slot, the stored address, its group label, whether it is a group of one, and whether it lies on a forced row or column. A later solver uses this to handle each group on its own.

Top module: `fault_group_preanalyzer`

## Requirements
- R1: A failure whose row and column both differ from every stored failure is stored and raises `group_cnt` by one at the accepting clock edge.
- R2: A failure that shares a row or a column with stored failures joins their group. When it links the group that owns its row with a different group that owns its column, `group_cnt` drops by one, and afterwards every member of both groups carries the same `rd_gid`.
- R3: After a linking failure is accepted, `flt_ready` is low from the next cycle until the relabel of every storage slot is finished (DEPTH cycles).
- R4: A failure whose row and column both equal those of a stored failure is accepted but not stored, and changes neither `group_cnt` nor any readout slot.
- R5: The store holds DEPTH failures. A further distinct failure sets the sticky `overflow` output, is dropped, and makes the final status irreparable (2'b10).
- R6: A row that holds more than SPARE_COLS stored failures is a forced row. `must_row_cnt` gives the number of distinct forced rows after analysis, and `rd_must_row` marks every slot on a forced row. More than SPARE_ROWS forced rows gives status 2'b10.
- R7: A column that holds more than SPARE_ROWS stored failures is a forced column. `must_col_cnt` gives the number of distinct forced columns, and `rd_must_col` marks the slots on them. More than SPARE_COLS forced columns gives status 2'b10.
- R8: When `group_cnt` is greater than SPARE_ROWS + SPARE_COLS at analysis, status becomes 2'b10. With exactly that many groups, and nothing else failing, status becomes 2'b11.
- R9: `status` reads 2'b00 (busy) from reset until analysis completes. A `test_done` pulse leads to a final status two clock edges after the edge that captures it: 2'b01 when no failure was stored, and 2'b11 when a search is needed.
- R10: The readout gives, for slot `rd_idx`, `rd_valid`, the stored row and column, `rd_gid`, and `rd_single`. `rd_single` is high exactly when no other stored failure carries the same `rd_gid`.
- R11: Once a final status is shown, it holds until reset. `flt_ready` stays low and incoming failures have no effect on `group_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | A failing cell address is offered |
| flt_ready | output | 1 | The block can take a failing cell address |
| flt_row | input | ROW_W | Row address of the failing cell |
| flt_col | input | COL_W | Column address of the failing cell |
| test_done | input | 1 | One-cycle strobe: no more failures will arrive |
| status | output | 2 | 00 busy, 01 no faults, 10 irreparable, 11 search needed |
| overflow | output | 1 | Sticky: a distinct failure arrived with the store full |
| group_cnt | output | CNT_W | Current number of fault groups |
| must_row_cnt | output | CNT_W | Distinct forced rows, valid after analysis |
| must_col_cnt | output | CNT_W | Distinct forced columns, valid after analysis |
| rd_idx | input | IDX_W | Storage slot selected for readout |
| rd_valid | output | 1 | Selected slot holds a failure |
| rd_row | output | ROW_W | Row of the selected failure |
| rd_col | output | COL_W | Column of the selected failure |
| rd_gid | output | IDX_W | Group label of the selected failure |
| rd_single | output | 1 | Selected failure forms a group of one |
| rd_must_row | output | 1 | Selected failure lies on a forced row |
| rd_must_col | output | 1 | Selected failure lies on a forced column |

## Verification
A wrong group label shows on the readout port at once: two failures on a common line read back with different `rd_gid`, or a linked failure keeps `rd_single` high. A wrong group counter shows on `group_cnt` one edge after the accepting handshake. It also shows in the final status when the count crosses the total spare budget, which the 4-group and 5-group cases are built to probe. A relabel that stops early shows only through the readout after the stall. A wrong forced-line decision shows in the forced counts and status two edges after `test_done` is captured.

// File: rtl/fgra_pkg.sv
package fgra_pkg;
   typedef enum logic [1:0] {
      ST_BUSY   = 2'b00,
      ST_NONE   = 2'b01,
      ST_IRREP  = 2'b10,
      ST_SEARCH = 2'b11
   } fg_status_e;

   typedef enum logic [1:0] {
      PH_COLLECT,
      PH_MERGE,
      PH_ANALYZE,
      PH_REPORT
   } fg_phase_e;
endpackage

// File: rtl/fg_match.sv
// Parallel compare of a new failure against every stored one.
// Groups own their lines exclusively, so any row hit names the same group.
module fg_match #(
   parameter int ROW_W = 6,
   parameter int COL_W = 6,
   parameter int DEPTH = 16,
   parameter int IDX_W = 4
) (
   input  logic [DEPTH-1:0]            vld,
   input  logic [DEPTH-1:0][ROW_W-1:0] rows,
   input  logic [DEPTH-1:0][COL_W-1:0] cols,
   input  logic [DEPTH-1:0][IDX_W-1:0] gids,
   input  logic [ROW_W-1:0]            q_row,
   input  logic [COL_W-1:0]            q_col,
   output logic                        dup,
   output logic                        row_hit,
   output logic                        col_hit,
   output logic [IDX_W-1:0]            row_gid,
   output logic [IDX_W-1:0]            col_gid
);
   always_comb begin
      dup     = 1'b0;
      row_hit = 1'b0;
      col_hit = 1'b0;
      row_gid = '0;
      col_gid = '0;
      for (int j = DEPTH - 1; j >= 0; j--) begin
         if (vld[j] && rows[j] == q_row) begin
            row_hit = 1'b1;
            row_gid = gids[j];
            if (cols[j] == q_col) dup = 1'b1;
         end
         if (vld[j] && cols[j] == q_col) begin
            col_hit = 1'b1;
            col_gid = gids[j];
         end
      end
   end
endmodule

// File: rtl/fg_line_eval.sv
// Forced-line evaluation along one axis: a line with more than LIMIT
// failures must take a spare of its own kind.
module fg_line_eval #(
   parameter int KEY_W = 6,
   parameter int DEPTH = 16,
   parameter int LIMIT = 2,
   parameter int CNT_W = 5
) (
   input  logic [DEPTH-1:0]            vld,
   input  logic [DEPTH-1:0][KEY_W-1:0] keys,
   output logic [DEPTH-1:0]            on_must,
   output logic [CNT_W-1:0]            must_lines
);
   logic [DEPTH-1:0] first_on_line;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [CNT_W-1:0] hits;
      logic             seen_before;
      always_comb begin
         hits        = '0;
         seen_before = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (vld[j] && keys[j] == keys[i]) begin
               hits = hits + CNT_W'(1);
               if (j < i) seen_before = 1'b1;
            end
         end
      end
      assign on_must[i]       = vld[i] && (int'(hits) > LIMIT);
      assign first_on_line[i] = !seen_before;
   end

   always_comb begin
      must_lines = '0;
      for (int i = 0; i < DEPTH; i++)
         if (on_must[i] && first_on_line[i]) must_lines = must_lines + CNT_W'(1);
   end
endmodule

// File: rtl/fault_group_preanalyzer.sv
module fault_group_preanalyzer
   import fgra_pkg::*;
#(
   parameter int ROW_W      = 6,
   parameter int COL_W      = 6,
   parameter int DEPTH      = 16,
   parameter int SPARE_ROWS = 2,
   parameter int SPARE_COLS = 2,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flt_valid,
   output logic             flt_ready,
   input  logic [ROW_W-1:0] flt_row,
   input  logic [COL_W-1:0] flt_col,
   input  logic             test_done,
   output logic [1:0]       status,
   output logic             overflow,
   output logic [CNT_W-1:0] group_cnt,
   output logic [CNT_W-1:0] must_row_cnt,
   output logic [CNT_W-1:0] must_col_cnt,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [ROW_W-1:0] rd_row,
   output logic [COL_W-1:0] rd_col,
   output logic [IDX_W-1:0] rd_gid,
   output logic             rd_single,
   output logic             rd_must_row,
   output logic             rd_must_col
);
   localparam int SPARE_SUM = SPARE_ROWS + SPARE_COLS;

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("fault_group_preanalyzer: DEPTH must be a power of two, at least 2");
   end
   if (SPARE_ROWS < 0 || SPARE_COLS < 0 || ROW_W < 1 || COL_W < 1) begin : g_bad_cfg
      $error("fault_group_preanalyzer: spare counts and address widths out of range");
   end

   logic [DEPTH-1:0]            ent_vld;
   logic [DEPTH-1:0][ROW_W-1:0] ent_row;
   logic [DEPTH-1:0][COL_W-1:0] ent_col;
   logic [DEPTH-1:0][IDX_W-1:0] ent_gid;
   logic [CNT_W-1:0]            fill;
   fg_phase_e                   phase;
   logic                        done_pend;
   logic [IDX_W-1:0]            sweep;
   logic [IDX_W-1:0]            mrg_from, mrg_to;
   fg_status_e                  status_q;
   logic                        ovf_q;
   logic [CNT_W-1:0]            grp_q, mr_q, mc_q;

   logic                        dup, row_hit, col_hit;
   logic [IDX_W-1:0]            row_gid, col_gid;
   logic [DEPTH-1:0]            must_row_vec, must_col_vec;
   logic [CNT_W-1:0]            must_rows, must_cols;

   fg_match #(.ROW_W(ROW_W), .COL_W(COL_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_match (
      .vld(ent_vld), .rows(ent_row), .cols(ent_col), .gids(ent_gid),
      .q_row(flt_row), .q_col(flt_col),
      .dup(dup), .row_hit(row_hit), .col_hit(col_hit),
      .row_gid(row_gid), .col_gid(col_gid));

   fg_line_eval #(.KEY_W(ROW_W), .DEPTH(DEPTH), .LIMIT(SPARE_COLS), .CNT_W(CNT_W)) u_rows (
      .vld(ent_vld), .keys(ent_row), .on_must(must_row_vec), .must_lines(must_rows));

   fg_line_eval #(.KEY_W(COL_W), .DEPTH(DEPTH), .LIMIT(SPARE_ROWS), .CNT_W(CNT_W)) u_cols (
      .vld(ent_vld), .keys(ent_col), .on_must(must_col_vec), .must_lines(must_cols));

   logic             accept, full;
   logic [IDX_W-1:0] slot;
   assign flt_ready = (phase == PH_COLLECT) && !done_pend;
   assign accept    = flt_valid && flt_ready;
   assign full      = (int'(fill) == DEPTH);
   assign slot      = fill[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld   <= '0;
         ent_row   <= '0;
         ent_col   <= '0;
         ent_gid   <= '0;
         fill      <= '0;
         phase     <= PH_COLLECT;
         done_pend <= 1'b0;
         sweep     <= '0;
         mrg_from  <= '0;
         mrg_to    <= '0;
         status_q  <= ST_BUSY;
         ovf_q     <= 1'b0;
         grp_q     <= '0;
         mr_q      <= '0;
         mc_q      <= '0;
      end else begin
         if (test_done && (phase == PH_COLLECT || phase == PH_MERGE)) done_pend <= 1'b1;
         unique case (phase)
            PH_COLLECT: begin
               if (accept && !dup) begin
                  if (full) begin
                     ovf_q <= 1'b1;
                  end else begin
                     ent_vld[slot] <= 1'b1;
                     ent_row[slot] <= flt_row;
                     ent_col[slot] <= flt_col;
                     ent_gid[slot] <= row_hit ? row_gid : (col_hit ? col_gid : slot);
                     fill          <= fill + CNT_W'(1);
                     if (!row_hit && !col_hit) begin
                        grp_q <= grp_q + CNT_W'(1);
                     end else if (row_hit && col_hit && row_gid != col_gid) begin
                        grp_q    <= grp_q - CNT_W'(1);
                        mrg_from <= col_gid;
                        mrg_to   <= row_gid;
                        sweep    <= '0;
                        phase    <= PH_MERGE;
                     end
                  end
               end else if (done_pend) begin
                  phase <= PH_ANALYZE;
               end
            end
            PH_MERGE: begin
               if (ent_vld[sweep] && ent_gid[sweep] == mrg_from) ent_gid[sweep] <= mrg_to;
               if (int'(sweep) == DEPTH - 1) phase <= PH_COLLECT;
               else                         sweep <= sweep + IDX_W'(1);
            end
            PH_ANALYZE: begin
               mr_q  <= must_rows;
               mc_q  <= must_cols;
               phase <= PH_REPORT;
               if (ovf_q)                              status_q <= ST_IRREP;
               else if (fill == '0)                    status_q <= ST_NONE;
               else if (int'(grp_q) > SPARE_SUM ||
                        int'(must_rows) > SPARE_ROWS ||
                        int'(must_cols) > SPARE_COLS)  status_q <= ST_IRREP;
               else                                    status_q <= ST_SEARCH;
            end
            default: ;
         endcase
      end
   end

   logic [CNT_W-1:0] mates;
   always_comb begin
      mates = '0;
      for (int j = 0; j < DEPTH; j++)
         if (ent_vld[j] && ent_gid[j] == ent_gid[rd_idx]) mates = mates + CNT_W'(1);
   end

   assign status       = status_q;
   assign overflow     = ovf_q;
   assign group_cnt    = grp_q;
   assign must_row_cnt = mr_q;
   assign must_col_cnt = mc_q;
   assign rd_valid     = ent_vld[rd_idx];
   assign rd_row       = ent_row[rd_idx];
   assign rd_col       = ent_col[rd_idx];
   assign rd_gid       = ent_gid[rd_idx];
   assign rd_single    = ent_vld[rd_idx] && (mates == CNT_W'(1));
   assign rd_must_row  = must_row_vec[rd_idx];
   assign rd_must_col  = must_col_vec[rd_idx];
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
   parameter int DEPTH      = 16,
   parameter int SPARE_ROWS = 2,
   parameter int SPARE_COLS = 2,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flt_valid,
   input logic             flt_ready,
   input logic [1:0]       status,
   input logic             overflow,
   input logic [CNT_W-1:0] group_cnt,
   input logic [CNT_W-1:0] must_row_cnt,
   input logic [CNT_W-1:0] must_col_cnt
);
   assert_no_change_without_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(flt_valid && flt_ready) |=> $stable(group_cnt));

   assert_group_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(group_cnt) <= DEPTH);

   assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   assert_overflow_rejects_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && status != 2'b00) |-> status == 2'b10);

   assert_search_within_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b11) |-> (int'(group_cnt) <= SPARE_ROWS + SPARE_COLS &&
                             int'(must_row_cnt) <= SPARE_ROWS &&
                             int'(must_col_cnt) <= SPARE_COLS));

   assert_empty_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b01) |-> (group_cnt == '0 && !overflow));

   assert_report_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 2'b00) |=> $stable(status));

   assert_report_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 2'b00) |-> !flt_ready);
endmodule

bind fault_group_preanalyzer fg_checker #(
   .DEPTH(DEPTH), .SPARE_ROWS(SPARE_ROWS), .SPARE_COLS(SPARE_COLS)
) u_fg_checker (
   .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
   .status(status), .overflow(overflow), .group_cnt(group_cnt),
   .must_row_cnt(must_row_cnt), .must_col_cnt(must_col_cnt));

// File: tb/fault_group_preanalyzer_bench.sv
`timescale 1ns/1ps
module fault_group_preanalyzer_bench;
   localparam int ROW_W = 6, COL_W = 6, DEPTH = 16, IDX_W = 4, CNT_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             flt_valid = 1'b0;
   logic             flt_ready;
   logic [ROW_W-1:0] flt_row = '0;
   logic [COL_W-1:0] flt_col = '0;
   logic             test_done = 1'b0;
   logic [1:0]       status;
   logic             overflow;
   logic [CNT_W-1:0] group_cnt, must_row_cnt, must_col_cnt;
   logic [IDX_W-1:0] rd_idx = '0;
   logic             rd_valid, rd_single, rd_must_row, rd_must_col;
   logic [ROW_W-1:0] rd_row;
   logic [COL_W-1:0] rd_col;
   logic [IDX_W-1:0] rd_gid;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   fault_group_preanalyzer #(.ROW_W(ROW_W), .COL_W(COL_W), .DEPTH(DEPTH),
                             .SPARE_ROWS(2), .SPARE_COLS(2)) u_fault_group_preanalyzer (
      .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
      .flt_row(flt_row), .flt_col(flt_col), .test_done(test_done),
      .status(status), .overflow(overflow), .group_cnt(group_cnt),
      .must_row_cnt(must_row_cnt), .must_col_cnt(must_col_cnt),
      .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_row(rd_row), .rd_col(rd_col),
      .rd_gid(rd_gid), .rd_single(rd_single), .rd_must_row(rd_must_row),
      .rd_must_col(rd_must_col));

   // {row, col, expected group count once fault entry is ready again}
   localparam logic [16:0] VEC [8] = '{
      {6'd1, 6'd1, 5'd1},   // R1 isolated
      {6'd2, 6'd2, 5'd2},   // R1 isolated
      {6'd1, 6'd5, 5'd2},   // R2 joins by row
      {6'd3, 6'd3, 5'd3},   // R1 isolated
      {6'd2, 6'd5, 5'd2},   // R2 links two groups
      {6'd1, 6'd1, 5'd2},   // R4 repeat
      {6'd1, 6'd7, 5'd2},   // R6 third fault on row 1
      {6'd4, 6'd4, 5'd3}    // R1 isolated
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; flt_valid = 1'b0; test_done = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_ready();
      for (int k = 0; k < 40 && !flt_ready; k++) @(negedge clk);
   endtask

   task automatic send(input int r, input int c, output logic rdy_next);
      wait_ready();
      flt_row = ROW_W'(r); flt_col = COL_W'(c); flt_valid = 1'b1;
      @(negedge clk);
      flt_valid = 1'b0;
      rdy_next = flt_ready;
      wait_ready();
   endtask

   task automatic finish_test();
      @(negedge clk);
      test_done = 1'b1;
      @(negedge clk);
      test_done = 1'b0;
      chk("R9 busy right after done", int'(status), 0);
      for (int k = 0; k < 20 && status == 2'b00; k++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic rdy;
      logic [IDX_W-1:0] g0;
      do_reset();
      chk("R9 reset status", int'(status), 0);
      chk("R5 reset overflow", int'(overflow), 0);
      chk("R1 reset group_cnt", int'(group_cnt), 0);
      chk("R3 reset ready", int'(flt_ready), 1);

      // table walk: grouping, merging, repeats
      for (int i = 0; i < 8; i++) begin
         send(int'(VEC[i][16:11]), int'(VEC[i][10:5]), rdy);
         if (i == 4) chk("R3 ready low during relabel", int'(rdy), 0);
         if (i == 5) chk("R4 repeat causes no stall", int'(rdy), 1);
         chk($sformatf("R1 R2 R4 group_cnt after vector %0d", i), int'(group_cnt), int'(VEC[i][4:0]));
      end
      finish_test();
      chk("R9 search needed", int'(status), 3);
      chk("R6 forced rows", int'(must_row_cnt), 1);
      chk("R7 forced cols", int'(must_col_cnt), 0);
      rd_idx = 4'd0; #1; g0 = rd_gid;
      chk("R6 slot0 on forced row", int'(rd_must_row), 1);
      chk("R10 slot0 not single", int'(rd_single), 0);
      rd_idx = 4'd1; #1;
      chk("R2 slot1 same label after link", int'(rd_gid), int'(g0));
      chk("R6 slot1 not on forced row", int'(rd_must_row), 0);
      rd_idx = 4'd4; #1;
      chk("R2 slot4 same label", int'(rd_gid), int'(g0));
      rd_idx = 4'd3; #1;
      chk("R10 slot3 single", int'(rd_single), 1);
      chk("R10 slot3 row", int'(rd_row), 3);
      chk("R2 slot3 separate label", int'(rd_gid != g0), 1);
      rd_idx = 4'd7; #1;
      chk("R4 repeat not stored, slot7 empty", int'(rd_valid), 0);
      rd_idx = 4'd5; #1;
      chk("R4 slot5 holds next distinct fault col", int'(rd_col), 7);
      // R11: entries after report are refused
      @(negedge clk);
      flt_row = 6'd9; flt_col = 6'd9; flt_valid = 1'b1;
      repeat (2) @(negedge clk);
      flt_valid = 1'b0;
      chk("R11 ready low after report", int'(flt_ready), 0);
      chk("R11 group_cnt unchanged", int'(group_cnt), 3);
      chk("R11 status held", int'(status), 3);

      // no faults
      do_reset();
      finish_test();
      chk("R9 no faults", int'(status), 1);

      // four isolated groups: exactly the spare budget
      do_reset();
      for (int i = 1; i <= 4; i++) send(i, i, rdy);
      finish_test();
      chk("R8 four groups search", int'(status), 3);
      rd_idx = 4'd2; #1;
      chk("R10 isolated single", int'(rd_single), 1);

      // five isolated groups: over budget
      do_reset();
      for (int i = 1; i <= 5; i++) send(i, i, rdy);
      chk("R1 five groups", int'(group_cnt), 5);
      finish_test();
      chk("R8 early termination", int'(status), 2);

      // store overflow, one group on row 0
      do_reset();
      for (int i = 0; i < 16; i++) send(0, i, rdy);
      chk("R5 full store no overflow", int'(overflow), 0);
      send(0, 16, rdy);
      chk("R5 overflow raised", int'(overflow), 1);
      chk("R5 group_cnt after overflow", int'(group_cnt), 1);
      finish_test();
      chk("R5 overflow irreparable", int'(status), 2);
      chk("R6 one forced row", int'(must_row_cnt), 1);

      // three forced columns
      do_reset();
      for (int c = 1; c <= 3; c++)
         for (int r = 0; r < 3; r++) send(3 * (c - 1) + r + 1, c, rdy);
      chk("R2 three column groups", int'(group_cnt), 3);
      finish_test();
      chk("R7 forced cols", int'(must_col_cnt), 3);
      chk("R6 no forced rows", int'(must_row_cnt), 0);
      chk("R7 too many forced cols", int'(status), 2);
      rd_idx = 4'd8; #1;
      chk("R7 slot8 on forced col", int'(rd_must_col), 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule